// File: doc/BRIEF.md
# Phase-Keyed Carrier Modulator with Optional Quadrature Stagger

This block turns a stream of two-bit symbols into a sampled, phase-modulated carrier. Each symbol supplies an in-phase bit and a quadrature bit. The in-phase bit sets the sign of a cosine carrier and the quadrature bit sets the sign of a sine carrier. The two signed carriers are added and leave the block as one signed sample per clock. The result sits at one of four phases: ±45° or ±135°.

A free-running carrier index steps through a fixed number of samples per carrier cycle (50 by default) and wraps to zero. Sine and cosine values are read from tables that are computed at elaboration time. A symbol is two bit periods long, and each bit period is a whole number of carrier cycles. New symbol bits therefore take effect only at a carrier-cycle boundary. Software-free upstream logic presents the bits with a one-clock strobe at any time during the current symbol. They are held until the next symbol boundary.

A mode input picks one of two modes. In aligned mode both branches switch at the symbol boundary. In staggered mode the quadrature branch is held back by one bit period, so the two branches never switch on the same clock.

Top module: `psk_carrier_mod`

## Requirements
- R1: `rst_n` low clears the output to zero at once, without waiting for a clock. It also clears the held and active bits of both branches to 0. Every sample of the first symbol after reset is therefore drawn with level -1 on both branches.
- R2: The carrier index advances by one every clock from 0 to N_SAMP-1 (default 50) and then wraps to 0. One carrier cycle is therefore N_SAMP clocks.
- R3: After each clock, `mod_sample` equals Li·C[k] + Lq·S[k]. Here k is the carrier index of the preceding clock, a bit of 1 gives level +1 and a bit of 0 gives level -1, C[k] = round(A·cos(2πk/N_SAMP)), S[k] = round(A·sin(2πk/N_SAMP)), and A = 2^(AMP_W-1)-1 = 2047. Rounding is half away from zero.
- R4: A bit period is CYC_PER_BIT carrier cycles (default 2), and a symbol is two bit periods (default 200 clocks). A new symbol first shows at the sample drawn at carrier index 0 after the boundary. The active bits do not change at any other clock.
- R5: A high `sym_stb` on a clock edge copies `sym_i` and `sym_q` into the holding stage. If several strobes arrive within one symbol, only the last one before the boundary is used.
- R6: With `offset_en` = 1, the quadrature bit lags by one bit period. During the first bit period of symbol s it uses the quadrature bit of symbol s-1, which is 0 for the first symbol after reset. During the second bit period it uses the quadrature bit of symbol s. The in-phase and quadrature bits never change on the same clock.
- R7: With `offset_en` = 0, both bits of a symbol take effect on the same clock at the symbol boundary.
- R8: `mod_sample` is a 14-bit signed sum that never overflows. Its magnitude never exceeds 2·A = 4094.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; one output sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| sym_stb | input | 1 | One-clock strobe that loads `sym_i`/`sym_q` into the holding stage |
| sym_i | input | 1 | In-phase bit of the next symbol (1 gives +1, 0 gives -1) |
| sym_q | input | 1 | Quadrature bit of the next symbol (1 gives +1, 0 gives -1) |
| offset_en | input | 1 | 0 selects aligned branches; 1 delays the quadrature branch by one bit period |
| mod_sample | output | 14 | Signed modulated carrier sample |

## Verification
The hardest case to reach from the ports is the staggered quadrature branch during the first bit period of a symbol. There the output depends on the quadrature bit that was strobed one symbol earlier, and after reset it depends on a cleared value that was never strobed. The bench runs a full sequence of symbols in each mode. It holds a shadow list of the bits in force for every symbol and predicts every sample from the clock count alone. Each half-symbol is therefore compared against the correct predecessor bit. Some symbols carry a decoy strobe with inverted bits ahead of the real one. This shows that only the last strobe before a boundary is used.

// File: rtl/psk_pkg.sv
package psk_pkg;

  // One symbol: in-phase and quadrature decision bits.
  typedef struct packed {
    logic i;
    logic q;
  } iq_bits_t;

  // Carrier table entry, rounded half away from zero. Evaluated at elaboration.
  function automatic int wave_point(input int idx, input int n_samp,
                                    input int amp, input bit want_cos);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(n_samp);
    v   = real'(amp) * (want_cos ? $cos(ang) : $sin(ang));
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

endpackage

// File: rtl/psk_phase_ctr.sv
module psk_phase_ctr #(
  parameter int N_SAMP      = 50,
  parameter int CYC_PER_BIT = 2,
  localparam int IDX_W      = $clog2(N_SAMP),
  localparam int BC_W       = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] phase_idx,
  output logic             cyc_wrap,
  output logic             bit_end,
  output logic             mid_end,
  output logic             sym_end
);

  logic [BC_W-1:0]  bit_cnt;
  logic [BC_W-1:0]  bit_cnt_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic             half;
  logic             half_nxt;
  logic             bit_last;

  always_comb begin
    cyc_wrap    = (phase_idx == IDX_W'(N_SAMP - 1));
    bit_last    = (bit_cnt == BC_W'(CYC_PER_BIT - 1));
    bit_end     = cyc_wrap && bit_last;
    mid_end     = bit_end && !half;
    sym_end     = bit_end && half;
    idx_nxt     = cyc_wrap ? '0 : phase_idx + IDX_W'(1);
    bit_cnt_nxt = bit_cnt;
    if (cyc_wrap) begin
      bit_cnt_nxt = bit_last ? '0 : bit_cnt + BC_W'(1);
    end
    half_nxt = bit_end ? !half : half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_idx <= '0;
      bit_cnt   <= '0;
      half      <= 1'b0;
    end else begin
      phase_idx <= idx_nxt;
      bit_cnt   <= bit_cnt_nxt;
      half      <= half_nxt;
    end
  end

endmodule

// File: rtl/psk_sym_align.sv
module psk_sym_align
  import psk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sym_stb,
  input  iq_bits_t sym_in,
  input  logic     offset_en,
  input  logic     sym_end,
  input  logic     mid_end,
  output iq_bits_t pend,
  output iq_bits_t cur
);

  logic q_dly;
  logic cur_q_nxt;
  logic cur_q_load;

  // Quadrature branch: aligned mode loads at the symbol edge,
  // staggered mode loads the delayed bit one bit period later.
  always_comb begin
    cur_q_load = offset_en ? mid_end : sym_end;
    cur_q_nxt  = offset_en ? q_dly : pend.q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else if (sym_stb) begin
      pend <= sym_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.i <= 1'b0;
      q_dly <= 1'b0;
    end else if (sym_end) begin
      cur.i <= pend.i;
      q_dly <= pend.q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur.q <= 1'b0;
    end else if (cur_q_load) begin
      cur.q <= cur_q_nxt;
    end
  end

endmodule

// File: rtl/psk_wave_rom.sv
module psk_wave_rom #(
  parameter int N_SAMP = 50,
  parameter int AMP_W  = 12,
  localparam int IDX_W = $clog2(N_SAMP),
  localparam int AMP   = (1 << (AMP_W - 1)) - 1
) (
  input  logic [IDX_W-1:0]        idx,
  output logic signed [AMP_W-1:0] cos_v,
  output logic signed [AMP_W-1:0] sin_v
);

  logic signed [AMP_W-1:0] cos_tab [N_SAMP];
  logic signed [AMP_W-1:0] sin_tab [N_SAMP];

  for (genvar k = 0; k < N_SAMP; k++) begin : g_tab
    localparam int CV = psk_pkg::wave_point(k, N_SAMP, AMP, 1'b1);
    localparam int SV = psk_pkg::wave_point(k, N_SAMP, AMP, 1'b0);
    assign cos_tab[k] = AMP_W'(CV);
    assign sin_tab[k] = AMP_W'(SV);
  end

  always_comb begin
    cos_v = cos_tab[idx];
    sin_v = sin_tab[idx];
  end

endmodule

// File: rtl/psk_mixer.sv
module psk_mixer #(
  parameter int AMP_W  = 12,
  parameter int OUT_W  = 14,
  localparam int SUM_W = AMP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [AMP_W-1:0] cos_v,
  input  logic signed [AMP_W-1:0] sin_v,
  input  logic                    lvl_i,
  input  logic                    lvl_q,
  output logic signed [OUT_W-1:0] mod_sample
);

  logic signed [SUM_W-1:0] cos_x;
  logic signed [SUM_W-1:0] sin_x;
  logic signed [SUM_W-1:0] term_i;
  logic signed [SUM_W-1:0] term_q;
  logic signed [SUM_W-1:0] sum;
  logic signed [OUT_W-1:0] out_nxt;

  // A +/-1 level is a sign select, so no multiplier is needed.
  always_comb begin
    cos_x   = SUM_W'(cos_v);
    sin_x   = SUM_W'(sin_v);
    term_i  = lvl_i ? cos_x : -cos_x;
    term_q  = lvl_q ? sin_x : -sin_x;
    sum     = term_i + term_q;
    out_nxt = OUT_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_sample <= '0;
    end else begin
      mod_sample <= out_nxt;
    end
  end

endmodule

// File: rtl/psk_carrier_mod.sv
module psk_carrier_mod #(
  parameter int N_SAMP      = 50,
  parameter int CYC_PER_BIT = 2,
  parameter int AMP_W       = 12,
  parameter int OUT_W       = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sym_stb,
  input  logic                    sym_i,
  input  logic                    sym_q,
  input  logic                    offset_en,
  output logic signed [OUT_W-1:0] mod_sample
);

  import psk_pkg::*;

  localparam int IDX_W = $clog2(N_SAMP);

  logic [IDX_W-1:0]        phase_idx;
  logic                    cyc_wrap;
  logic                    bit_end;
  logic                    mid_end;
  logic                    sym_end;
  iq_bits_t                sym_in;
  iq_bits_t                pend;
  iq_bits_t                cur;
  logic                    pend_q;
  logic                    cur_i;
  logic                    cur_q;
  logic signed [AMP_W-1:0] cos_v;
  logic signed [AMP_W-1:0] sin_v;

  always_comb begin
    sym_in.i = sym_i;
    sym_in.q = sym_q;
    pend_q   = pend.q;
    cur_i    = cur.i;
    cur_q    = cur.q;
  end

  psk_phase_ctr #(
    .N_SAMP      (N_SAMP),
    .CYC_PER_BIT (CYC_PER_BIT)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_idx (phase_idx),
    .cyc_wrap  (cyc_wrap),
    .bit_end   (bit_end),
    .mid_end   (mid_end),
    .sym_end   (sym_end)
  );

  psk_sym_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .sym_in    (sym_in),
    .offset_en (offset_en),
    .sym_end   (sym_end),
    .mid_end   (mid_end),
    .pend      (pend),
    .cur       (cur)
  );

  psk_wave_rom #(
    .N_SAMP (N_SAMP),
    .AMP_W  (AMP_W)
  ) u_rom (
    .idx   (phase_idx),
    .cos_v (cos_v),
    .sin_v (sin_v)
  );

  psk_mixer #(
    .AMP_W (AMP_W),
    .OUT_W (OUT_W)
  ) u_mix (
    .clk        (clk),
    .rst_n      (rst_n),
    .cos_v      (cos_v),
    .sin_v      (sin_v),
    .lvl_i      (cur_i),
    .lvl_q      (cur_q),
    .mod_sample (mod_sample)
  );

endmodule

// File: rtl/psk_carrier_mod_chk.sv
module psk_carrier_mod_chk #(
  parameter int N_SAMP = 50,
  parameter int AMP_W  = 12,
  parameter int OUT_W  = 14,
  localparam int IDX_W = $clog2(N_SAMP),
  localparam int PEAK  = 2 * ((1 << (AMP_W - 1)) - 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [IDX_W-1:0]        phase_idx,
  input logic                    cyc_wrap,
  input logic                    sym_end,
  input logic                    offset_en,
  input logic                    pend_q,
  input logic                    cur_i,
  input logic                    cur_q,
  input logic signed [OUT_W-1:0] mod_sample
);

  // R2
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_idx == IDX_W'(N_SAMP - 1)) |=> (phase_idx == '0));

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_idx != IDX_W'(N_SAMP - 1)) |=> (phase_idx == $past(phase_idx) + IDX_W'(1)));

  // R4
  sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wrap |=> ($stable(cur_i) && $stable(cur_q)));

  // R6
  stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offset_en |=> !(!$stable(cur_i) && !$stable(cur_q)));

  // R7
  aligned_q_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!offset_en && sym_end) |=> (cur_q == $past(pend_q)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_sample <= PEAK) && (mod_sample >= -PEAK));

endmodule

bind psk_carrier_mod psk_carrier_mod_chk #(
  .N_SAMP (N_SAMP),
  .AMP_W  (AMP_W),
  .OUT_W  (OUT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_idx  (phase_idx),
  .cyc_wrap   (cyc_wrap),
  .sym_end    (sym_end),
  .offset_en  (offset_en),
  .pend_q     (pend_q),
  .cur_i      (cur_i),
  .cur_q      (cur_q),
  .mod_sample (mod_sample)
);

// File: tb/psk_carrier_mod_bench.sv
module psk_carrier_mod_bench;

  localparam int N    = 50;
  localparam int CPB  = 2;
  localparam int AMPL = 2047;
  localparam int SYML = N * CPB * 2;
  localparam int NSYM = 9;

  // Stimulus table, one entry per symbol after the first: {decoy, i, q}.
  localparam logic [2:0] VEC [0:7] = '{
    3'b011, 3'b010, 3'b101, 3'b111,
    3'b000, 3'b110, 3'b001, 3'b100
  };

  logic clk;
  logic rst_n;
  logic sym_stb;
  logic sym_i;
  logic sym_q;
  logic offset_en;
  logic signed [13:0] mod_sample;

  int n_cmp;
  int n_bad;
  bit mode_r;
  bit si [0:NSYM-1];
  bit sq [0:NSYM-1];
  bit dec [0:NSYM-1];

  psk_carrier_mod u_psk_carrier_mod (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_stb    (sym_stb),
    .sym_i      (sym_i),
    .sym_q      (sym_q),
    .offset_en  (offset_en),
    .mod_sample (mod_sample)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ideal(int k, bit use_cos);
    real a;
    real v;
    a = 2.0 * 3.14159265358979 * real'(k) / real'(N);
    v = real'(AMPL) * (use_cos ? $cos(a) : $sin(a));
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic int expect_at(int m);
    int k    = m % N;
    int b    = (m / N) / CPB;
    int s    = b / 2;
    int half = b % 2;
    bit ib   = si[s];
    bit qb;
    if (mode_r) qb = half ? sq[s] : ((s == 0) ? 1'b0 : sq[s-1]);
    else        qb = sq[s];
    return (ib ? ideal(k, 1) : -ideal(k, 1)) + (qb ? ideal(k, 0) : -ideal(k, 0));
  endfunction

  task automatic check(string req, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic run_mode(bit mode);
    offset_en = mode;
    mode_r    = mode;
    sym_stb   = 1'b0;
    sym_i     = 1'b0;
    sym_q     = 1'b0;
    rst_n     = 1'b0;
    @(negedge clk);
    check("R1 reset output", int'(mod_sample), 0);
    si[0] = 1'b0; sq[0] = 1'b0; dec[0] = 1'b0;
    for (int s = 1; s < NSYM; s++) begin
      dec[s] = VEC[s-1][2];
      si[s]  = VEC[s-1][1];
      sq[s]  = VEC[s-1][0];
    end
    rst_n = 1'b1;
    for (int k = 1; k <= NSYM * SYML; k++) begin
      int m;
      int s;
      int half;
      string tag;
      @(negedge clk);
      sym_stb = 1'b0;
      m    = k - 1;
      s    = m / SYML;
      half = ((m / N) / CPB) % 2;
      if (m < SYML)                   tag = "R1 first symbol";
      else if (m % SYML == 0)         tag = "R4 boundary";
      else if (mode && half == 0)     tag = "R6 staggered q";
      else if (dec[s])                tag = "R5 last strobe";
      else if (m % N == N - 1)        tag = "R2 wrap";
      else if (!mode)                 tag = "R7 aligned";
      else                            tag = "R3 sample";
      check(tag, int'(mod_sample), expect_at(m));
      check("R8 range", (mod_sample <= 4094 && mod_sample >= -4094) ? 1 : 0, 1);
      if (k % SYML == 20 && k / SYML + 1 < NSYM && dec[k / SYML + 1]) begin
        sym_i   = ~si[k / SYML + 1];
        sym_q   = ~sq[k / SYML + 1];
        sym_stb = 1'b1;
      end
      if (k % SYML == 60 && k / SYML + 1 < NSYM) begin
        sym_i   = si[k / SYML + 1];
        sym_q   = sq[k / SYML + 1];
        sym_stb = 1'b1;
      end
    end
    // R1: asynchronous clear in mid-run, observed before any clock edge.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", int'(mod_sample), 0);
  endtask

  initial begin
    n_cmp = 0;
    n_bad = 0;
    rst_n = 1'b0;
    run_mode(1'b0);
    run_mode(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule